// File: doc/BRIEF.md
# DMA Channel Debug Suspend Controller

This block stops a configurable set of DMA channels when a debug unit asks for a suspend. Software marks the channels that should take part by setting bits in an enable word. While the debug request is high, each marked channel gets a hold signal. The hold is raised only when the channel has no transfer in progress, so no transfer is ever cut in half. Once held, the channel's state is frozen against hardware updates. Software can still write the enable word.

The hold output for each channel also serves as that channel's readable suspend-active flag. The debug unit gets a single acknowledge. It rises once two things are true: every enabled channel is held, and none of the bus master interfaces has a read or write pending. Channels that are not enabled are never held. They keep running for the whole debug session.

When the request drops, every hold, flag and the acknowledge clear together and the channels resume.

Top module: `dbg_suspend_ctrl`

## Requirements
- R1: After reset the enable word, every hold/flag bit and `sus_ack` are 0.
- R2: Register address 0 holds the enable word, one bit per channel. Bit i is channel i, it is read/write, and bits at or above NCH read 0. Address 1 holds the status word, with bit i equal to channel i's suspend-active flag. The status word is read-only and writes to it have no effect. `reg_rdata` is combinational on `reg_addr`.
- R3: Consider a clock edge where `sus_req`=1, channel i is enabled and `xfer_busy[i]`=0. Channel i's flag and `hold[i]` are 1 after that edge.
- R4: While `xfer_busy[i]`=1, a channel whose flag is 0 does not get its flag set.
- R5: A channel whose enable bit is 0 never has its flag or hold set.
- R6: `hold[i]` always equals the status word's bit i.
- R7: `sus_ack` is 1 after an edge exactly when, at that edge, three things hold: `sus_req`=1, no `bus_busy` bit is set, and every channel enabled after the edge is flagged after the edge.
- R8: Any pending bus-master operation (`bus_busy` non-zero) keeps `sus_ack` at 0, even when all enabled channels are held.
- R9: With `sus_req`=1 and no channel enabled, `sus_ack` rises after the first edge with `bus_busy`=0.
- R10: An edge with `sus_req`=0 clears all flags, holds and `sus_ack`.
- R11: Setting an enable bit while the request is active suspends that channel at its next transfer boundary. Clearing an enable bit clears that channel's flag and hold at the write's own edge.
- R12: While the request stays active and the channel stays enabled, a set flag remains set whatever `xfer_busy` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sus_req | input | 1 | Suspend request from the debug unit |
| xfer_busy | input | NCH | Per-channel transfer in progress |
| bus_busy | input | NBM | Per-bus-master pending read/write |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable word, 1 = status word |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| hold | output | NCH | Per-channel freeze, equal to the suspend-active flag |
| sus_ack | output | 1 | Suspend acknowledge to the debug unit |

## Verification
The bench raises the request in several situations. In one, some enabled channels are idle while another is mid-transfer. This separates an immediate freeze from a freeze deferred to the transfer boundary. A disabled channel is kept busy and toggling throughout, to show it is never held. The bus-busy lines are held high after all channels are frozen, which separates channel completion from acknowledge. Enable bits are set and cleared during an active request, and a session with no enabled channel covers the acknowledge that depends only on the bus.

// File: rtl/dbg_suspend_ctrl.sv
module dbg_suspend_ctrl #(
  parameter int NCH = 4,
  parameter int NBM = 2,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sus_req,
  input  logic [NCH-1:0] xfer_busy,
  input  logic [NBM-1:0] bus_busy,
  input  logic           reg_wr,
  input  logic           reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic [NCH-1:0] hold,
  output logic           sus_ack
);
  logic [NCH-1:0] en_q, act_q, en_nx, act_nx;
  logic           ack_q, en_wr, ack_nx;

  assign en_wr  = reg_wr && (reg_addr == 1'b0);
  assign en_nx  = en_wr ? reg_wdata[NCH-1:0] : en_q;
  assign act_nx = {NCH{sus_req}} & en_nx & (act_q | ~xfer_busy);
  assign ack_nx = sus_req && !(|bus_busy) && (&(act_nx | ~en_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      act_q <= '0;
      ack_q <= 1'b0;
    end else begin
      en_q  <= en_nx;
      act_q <= act_nx;
      ack_q <= ack_nx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[NCH-1:0] = reg_addr ? act_q : en_q;
  end

  generate
    if (DW > NCH) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^reg_wdata[DW-1:NCH];
    end
  endgenerate

  assign hold    = act_q;
  assign sus_ack = ack_q;
endmodule

// File: rtl/dbg_suspend_chk.sv
module dbg_suspend_chk #(
  parameter int NCH = 4,
  parameter int NBM = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sus_req,
  input logic [NCH-1:0] xfer_busy,
  input logic [NBM-1:0] bus_busy,
  input logic           reg_wr,
  input logic           reg_addr,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] hold,
  input logic           sus_ack
);
  // R10
  release_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sus_req |=> (hold == '0) && !sus_ack);

  // R8
  ack_needs_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_busy) |=> !sus_ack);

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      // R4
      no_mid_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold[i] && xfer_busy[i]) |=> !hold[i]);

      // R3
      idle_enabled_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sus_req && en_q[i] && !xfer_busy[i] && !(reg_wr && !reg_addr)) |=> hold[i]);

      // R12
      flag_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold[i] && sus_req && en_q[i] && !(reg_wr && !reg_addr)) |=> hold[i]);
    end
  endgenerate
endmodule

bind dbg_suspend_ctrl dbg_suspend_chk #(.NCH(NCH), .NBM(NBM)) u_chk (
  .clk(clk), .rst_n(rst_n), .sus_req(sus_req), .xfer_busy(xfer_busy),
  .bus_busy(bus_busy), .reg_wr(reg_wr), .reg_addr(reg_addr), .en_q(en_q),
  .hold(hold), .sus_ack(sus_ack)
);

// File: tb/sim_dbg_suspend_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_suspend_ctrl;
  localparam int NCH = 4, NBM = 2, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, sus_req = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [NCH-1:0] xfer_busy = '0;
  logic [NBM-1:0] bus_busy = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] hold;
  logic sus_ack;

  always #10 clk = ~clk;

  dbg_suspend_ctrl #(.NCH(NCH), .NBM(NBM), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sus_req(sus_req), .xfer_busy(xfer_busy),
    .bus_busy(bus_busy), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hold(hold), .sus_ack(sus_ack)
  );

  typedef struct { string rq; int sel; logic [DW-1:0] exp; } item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic expect_v(string rq, int sel, logic [DW-1:0] exp);
    item_t it;
    it.rq = rq; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(logic a, logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic check_state(string rq, logic [NCH-1:0] h, logic a);
    expect_v(rq, 0, DW'(h));
    expect_v(rq, 1, DW'(a));
  endtask

  task automatic check_reg(string rq, logic a, logic [DW-1:0] v);
    reg_addr = a;
    expect_v(rq, 2, v);
    @(negedge clk); #1;
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [DW-1:0] got;
      it = sb.pop_front();
      case (it.sel)
        0: got = DW'(hold);
        1: got = DW'(sus_ack);
        default: got = reg_rdata;
      endcase
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.rq, it.sel, got, it.exp);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=hung expected=finished");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none

    #25 rst_n = 1'b1;
    tick();
    check_state("R1", 4'b0000, 1'b0);
    check_reg("R1", 1'b0, 16'h0000);
    check_reg("R1", 1'b1, 16'h0000);

    wr_reg(1'b0, 16'hFFF5);
    check_reg("R2", 1'b0, 16'h0005);
    wr_reg(1'b1, 16'h000F);
    check_reg("R2", 1'b1, 16'h0000);

    // ch0 enabled but busy, ch2 enabled and idle, ch1/ch3 disabled
    xfer_busy = 4'b0001; bus_busy = 2'b01; sus_req = 1'b1;
    tick();
    check_state("R3_R4", 4'b0100, 1'b0);
    xfer_busy = 4'b1011;
    tick();
    check_state("R4_R5", 4'b0100, 1'b0);
    xfer_busy = 4'b1010;
    tick();
    check_state("R3_R8", 4'b0101, 1'b0);
    check_reg("R6", 1'b1, 16'h0005);
    xfer_busy = 4'b1111;
    tick();
    check_state("R12_R8", 4'b0101, 1'b0);
    bus_busy = 2'b00;
    tick();
    check_state("R7", 4'b0101, 1'b1);

    xfer_busy = 4'b0010;
    wr_reg(1'b0, 16'h0007);
    check_state("R11_R7", 4'b0101, 1'b0);
    xfer_busy = 4'b0000;
    tick();
    check_state("R11", 4'b0111, 1'b1);
    check_reg("R6", 1'b1, 16'h0007);
    wr_reg(1'b0, 16'h0006);
    check_state("R11", 4'b0110, 1'b1);

    sus_req = 1'b0;
    tick();
    check_state("R10", 4'b0000, 1'b0);
    check_reg("R10", 1'b1, 16'h0000);

    wr_reg(1'b0, 16'h0000);
    bus_busy = 2'b10; sus_req = 1'b1;
    tick();
    check_state("R9", 4'b0000, 1'b0);
    bus_busy = 2'b00;
    tick();
    check_state("R9", 4'b0000, 1'b1);
    sus_req = 1'b0;
    tick();
    check_state("R10", 4'b0000, 1'b0);

    @(negedge clk); #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule